// File: doc/BRIEF.md
# Cache-Line Store Monitor with Wait

This block gives one hardware context a way to sleep until a chosen memory line is written. Software first arms the monitor with an address; the block keeps only the 64-byte line that address falls in and clears its event flag. A snoop port sees every memory write in the system, including writes from this context, each given as a start address and a byte count. Any write whose bytes land anywhere inside the armed line raises the event flag. An interrupt raises it too. A wait command then parks the context in a sleep state until the flag goes up, and the block reports whether a store or an interrupt ended the wait.

The monitor is single-shot. Each wake, whether at once or after sleeping, disarms it. A later wait with no new arm does nothing, so software must arm again inside its retry loop. The wake cause lets software tell a real notification (a store) from a spurious exit (an interrupt) without reading memory.

The snoop port carries only a valid strobe and has no back-pressure. The monitor accepts a write in every cycle that valid is high and cannot stall the memory system. Arm, wait and interrupt are plain single-cycle control pulses.

Top module: `store_line_monitor`

## Requirements
- R1: After reset, `asleep`, `wake` and `evt_pending` are 0 and `wake_cause` is 0 (none).
- R2: An arm pulse stores the line number `arm_addr[31:6]`, ignoring the low 6 address bits. In the next cycle `evt_pending` is 0 and `wake_cause` is 0.
- R3: While armed, a snoop write with `snp_len` ≥ 1 whose byte span `[snp_addr, snp_addr+snp_len-1]` overlaps the armed line sets `evt_pending` and `wake_cause` = 1 (store) in the next cycle. A span that starts below the line and reaches into it counts as a hit. A span that ends just before the line, starts just after it, or has `snp_len` = 0 does not.
- R4: While armed, `irq` sets `evt_pending` with `wake_cause` = 2 (interrupt). If a hit and `irq` arrive in the same cycle, the cause is store. Once the flag is set, the cause of the first event is kept until the next arm.
- R5: A wait while armed with no event pending puts the context to sleep: `asleep` = 1 in the next cycle.
- R6: While asleep, a hit or `irq` clears `asleep` and pulses `wake` for exactly one cycle in the next cycle. `wake_cause` gives the cause.
- R7: A wait while armed with the flag already set (or an event in that same cycle) never sets `asleep`. `wake` pulses in the next cycle.
- R8: Every wake disarms the monitor. A later wait leaves `asleep` and `wake` at 0, and later writes to the old line leave `evt_pending` and `wake_cause` unchanged.
- R9: A wait with no arm since reset is a no-op: `asleep` and `wake` stay 0.
- R10: An arm takes priority in its cycle. A wait, a hit or an `irq` in that same cycle is discarded, and the new line is the one watched afterwards.
- R11: While unarmed, `irq` and snoop writes do not change `evt_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid | input | 1 | Arm pulse: latch line, clear event flag |
| arm_addr | input | 32 | Address whose 64-byte line is monitored |
| wait_req | input | 1 | Wait pulse |
| snp_valid | input | 1 | Snooped write valid (no back-pressure) |
| snp_addr | input | 32 | Start byte address of snooped write |
| snp_len | input | 4 | Byte count of snooped write (0 = no bytes) |
| irq | input | 1 | Interrupt/exception event |
| asleep | output | 1 | Context is in sleep state |
| wake | output | 1 | One-cycle pulse when a wait completes |
| evt_pending | output | 1 | Event-pending flag |
| wake_cause | output | 2 | 0 none, 1 store, 2 interrupt |

## Verification
A wrong line register or a bad overlap compare shows up one cycle after the snooped write. Either `evt_pending` rises when it should not, or a sleeping context fails to wake. Stale arm state shows up one cycle after the next wait: `asleep` rises or `wake` pulses where neither should. A cause latch that is overwritten or cleared at the wrong time changes `wake_cause` in the cycle after the second event or the arm. Each of these faults can be seen at the ports within one or two cycles of the stimulus.

// File: rtl/smon_pkg.sv
package smon_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_STORE = 2'd1,
    CAUSE_IRQ   = 2'd2
  } cause_e;
endpackage

// File: rtl/smon_line_match.sv
module smon_line_match #(
  parameter int AW   = 32,
  parameter int OFS  = 6,
  parameter int LENW = 4
) (
  input  logic [AW-OFS-1:0] line_q,
  input  logic              snp_valid,
  input  logic [AW-1:0]     snp_addr,
  input  logic [LENW-1:0]   snp_len,
  output logic              hit
);
  localparam int LW = AW - OFS;

  logic [AW:0] end_byte;
  logic [LW:0] first_line, last_line, tgt_line;
  logic        unused_end;

  always_comb begin
    end_byte   = {1'b0, snp_addr} + {{(AW+1-LENW){1'b0}}, snp_len} - {{AW{1'b0}}, 1'b1};
    first_line = {1'b0, snp_addr[AW-1:OFS]};
    last_line  = end_byte[AW:OFS];
    tgt_line   = {1'b0, line_q};
    hit = snp_valid && (snp_len != '0) &&
          (first_line <= tgt_line) && (last_line >= tgt_line);
  end

  assign unused_end = ^end_byte[OFS-1:0];
endmodule

// File: rtl/smon_ctx_ctrl.sv
module smon_ctx_ctrl
  import smon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   arm_valid,
  input  logic   wait_req,
  input  logic   hit,
  input  logic   irq,
  output logic   asleep,
  output logic   wake,
  output logic   pending,
  output cause_e cause
);
  logic   armed_q, asleep_q, wake_q, pend_q;
  cause_e cause_q;
  logic   ev;
  cause_e ev_cause;

  always_comb begin
    ev       = armed_q && (hit || irq);
    ev_cause = hit ? CAUSE_STORE : CAUSE_IRQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      asleep_q <= 1'b0;
      wake_q   <= 1'b0;
      pend_q   <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      wake_q <= 1'b0;
      if (arm_valid) begin
        armed_q <= 1'b1;
        pend_q  <= 1'b0;
        cause_q <= CAUSE_NONE;
      end else begin
        if (ev && !pend_q) begin
          pend_q  <= 1'b1;
          cause_q <= ev_cause;
        end
        if (asleep_q) begin
          if (ev) begin
            asleep_q <= 1'b0;
            wake_q   <= 1'b1;
            armed_q  <= 1'b0;
          end
        end else if (wait_req && armed_q) begin
          if (pend_q || ev) begin
            wake_q  <= 1'b1;
            armed_q <= 1'b0;
          end else begin
            asleep_q <= 1'b1;
          end
        end
      end
    end
  end

  assign asleep  = asleep_q;
  assign wake    = wake_q;
  assign pending = pend_q;
  assign cause   = cause_q;
endmodule

// File: rtl/store_line_monitor.sv
module store_line_monitor
  import smon_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int LENW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_valid,
  input  logic [AW-1:0] arm_addr,
  input  logic          wait_req,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic [LENW-1:0] snp_len,
  input  logic          irq,
  output logic          asleep,
  output logic          wake,
  output logic          evt_pending,
  output logic [1:0]    wake_cause
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int LW  = AW - OFS;

  logic [LW-1:0] line_q;
  logic          hit;
  logic          unused_lo;
  cause_e        cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         line_q <= '0;
    else if (arm_valid) line_q <= arm_addr[AW-1:OFS];
  end

  assign unused_lo = ^arm_addr[OFS-1:0];

  smon_line_match #(.AW(AW), .OFS(OFS), .LENW(LENW)) u_match (
    .line_q    (line_q),
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr),
    .snp_len   (snp_len),
    .hit       (hit)
  );

  smon_ctx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_valid (arm_valid),
    .wait_req  (wait_req),
    .hit       (hit),
    .irq       (irq),
    .asleep    (asleep),
    .wake      (wake),
    .pending   (evt_pending),
    .cause     (cause)
  );

  assign wake_cause = cause;
endmodule

// File: rtl/smon_chk.sv
module smon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_valid,
  input logic       wait_req,
  input logic       irq,
  input logic       asleep,
  input logic       wake,
  input logic       evt_pending,
  input logic [1:0] wake_cause
);
  // R2
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_valid |=> (!evt_pending && wake_cause == 2'd0 && !wake));

  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(wait_req));

  // R5
  sleep_nopend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !evt_pending);

  // R6
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && irq && !arm_valid) |=> (wake && !asleep));

  // R6
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R6
  fall_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> wake);

  // R3
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pending |-> (wake_cause != 2'd0));
endmodule

bind store_line_monitor smon_chk u_smon_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_valid   (arm_valid),
  .wait_req    (wait_req),
  .irq         (irq),
  .asleep      (asleep),
  .wake        (wake),
  .evt_pending (evt_pending),
  .wake_cause  (wake_cause)
);

// File: tb/tb_store_line_monitor.sv
`timescale 1ns/1ps
module tb_store_line_monitor;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_ARM = 3'd1, OP_ST = 3'd2,
                         OP_IRQ = 3'd3, OP_WAIT = 3'd4, OP_STIRQ = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] addr;
    logic [3:0]  len;
    logic [3:0]  req;
    logic        e_sl;
    logic        e_wk;
    logic        e_pd;
    logic [1:0]  e_cs;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_ARM,   32'h0000_1020, 4'd0, 4'd2,  1'b0, 1'b0, 1'b0, 2'd0}, // R2
    '{OP_ST,    32'h0000_0FF8, 4'd8, 4'd3,  1'b0, 1'b0, 1'b0, 2'd0}, // R3 ends before line
    '{OP_ST,    32'h0000_1040, 4'd1, 4'd3,  1'b0, 1'b0, 1'b0, 2'd0}, // R3 starts after line
    '{OP_ST,    32'h0000_103C, 4'd0, 4'd3,  1'b0, 1'b0, 1'b0, 2'd0}, // R3 zero length
    '{OP_WAIT,  32'h0,         4'd0, 4'd5,  1'b1, 1'b0, 1'b0, 2'd0}, // R5
    '{OP_IDLE,  32'h0,         4'd0, 4'd5,  1'b1, 1'b0, 1'b0, 2'd0}, // R5
    '{OP_ST,    32'h0000_0FFC, 4'd8, 4'd6,  1'b0, 1'b1, 1'b1, 2'd1}, // R6 R3 straddle
    '{OP_IDLE,  32'h0,         4'd0, 4'd6,  1'b0, 1'b0, 1'b1, 2'd1}, // R6 one-cycle pulse
    '{OP_WAIT,  32'h0,         4'd0, 4'd8,  1'b0, 1'b0, 1'b1, 2'd1}, // R8 disarmed wait
    '{OP_IRQ,   32'h0,         4'd0, 4'd8,  1'b0, 1'b0, 1'b1, 2'd1}, // R8 irq ignored
    '{OP_ARM,   32'h0000_2000, 4'd0, 4'd2,  1'b0, 1'b0, 1'b0, 2'd0}, // R2
    '{OP_IRQ,   32'h0,         4'd0, 4'd4,  1'b0, 1'b0, 1'b1, 2'd2}, // R4
    '{OP_ST,    32'h0000_2010, 4'd4, 4'd4,  1'b0, 1'b0, 1'b1, 2'd2}, // R4 first cause kept
    '{OP_WAIT,  32'h0,         4'd0, 4'd7,  1'b0, 1'b1, 1'b1, 2'd2}, // R7
    '{OP_ARM,   32'h0000_2005, 4'd0, 4'd2,  1'b0, 1'b0, 1'b0, 2'd0}, // R2
    '{OP_WAIT,  32'h0,         4'd0, 4'd5,  1'b1, 1'b0, 1'b0, 2'd0}, // R5
    '{OP_IRQ,   32'h0,         4'd0, 4'd6,  1'b0, 1'b1, 1'b1, 2'd2}, // R6 irq wake
    '{OP_ARM,   32'h0000_3000, 4'd0, 4'd2,  1'b0, 1'b0, 1'b0, 2'd0}, // R2
    '{OP_ST,    32'h0000_303F, 4'd1, 4'd3,  1'b0, 1'b0, 1'b1, 2'd1}, // R3 last byte
    '{OP_ARM,   32'h0000_3000, 4'd0, 4'd2,  1'b0, 1'b0, 1'b0, 2'd0}, // R2
    '{OP_WAIT,  32'h0,         4'd0, 4'd5,  1'b1, 1'b0, 1'b0, 2'd0}, // R5
    '{OP_STIRQ, 32'h0000_3000, 4'd2, 4'd4,  1'b0, 1'b1, 1'b1, 2'd1}  // R4 store beats irq
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_valid = 1'b0, wait_req = 1'b0, snp_valid = 1'b0, irq = 1'b0;
  logic [31:0] arm_addr = '0, snp_addr = '0;
  logic [3:0]  snp_len = '0;
  logic        asleep, wake, evt_pending;
  logic [1:0]  wake_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  store_line_monitor dut (
    .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_addr(arm_addr),
    .wait_req(wait_req), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_len(snp_len), .irq(irq), .asleep(asleep), .wake(wake),
    .evt_pending(evt_pending), .wake_cause(wake_cause)
  );

  task automatic chk(input string rq, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, got, exp);
    end
  endtask

  task automatic chk_all(input string rq, input int sl, input int wk, input int pd, input int cs);
    chk(rq, "asleep", int'(asleep), sl);
    chk(rq, "wake", int'(wake), wk);
    chk(rq, "evt_pending", int'(evt_pending), pd);
    chk(rq, "wake_cause", int'(wake_cause), cs);
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [3:0] l);
    arm_valid = (op == OP_ARM);
    wait_req  = (op == OP_WAIT);
    irq       = (op == OP_IRQ) || (op == OP_STIRQ);
    snp_valid = (op == OP_ST) || (op == OP_STIRQ);
    arm_addr  = a;
    snp_addr  = a;
    snp_len   = l;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1", 0, 0, 0, 0);

    // R9: wait with no arm since reset
    drive(OP_WAIT, 32'h0, 4'd0);
    @(negedge clk);
    drive(OP_IDLE, 32'h0, 4'd0);
    chk("R9", "asleep", int'(asleep), 0);
    chk("R9", "wake", int'(wake), 0);

    // R11: events while unarmed
    drive(OP_STIRQ, 32'h0000_0000, 4'd4);
    @(negedge clk);
    drive(OP_IDLE, 32'h0, 4'd0);
    chk("R11", "evt_pending", int'(evt_pending), 0);
    chk("R11", "wake_cause", int'(wake_cause), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].addr, VEC[i].len);
      @(negedge clk);
      chk_all($sformatf("R%0d vec%0d", VEC[i].req, i),
              int'(VEC[i].e_sl), int'(VEC[i].e_wk), int'(VEC[i].e_pd), int'(VEC[i].e_cs));
    end
    drive(OP_IDLE, 32'h0, 4'd0);
    @(negedge clk);

    // R10: arm together with wait, store and irq
    arm_valid = 1'b1; arm_addr = 32'h0000_4000;
    wait_req = 1'b1; irq = 1'b1;
    snp_valid = 1'b1; snp_addr = 32'h0000_4000; snp_len = 4'd1;
    @(negedge clk);
    drive(OP_IDLE, 32'h0, 4'd0);
    chk_all("R10", 0, 0, 0, 0);
    @(negedge clk);
    chk_all("R10", 0, 0, 0, 0);
    drive(OP_WAIT, 32'h0, 4'd0);
    @(negedge clk);
    chk("R10", "asleep", int'(asleep), 1);
    drive(OP_ST, 32'h0000_3020, 4'd1);
    @(negedge clk);
    chk("R10", "asleep old line", int'(asleep), 1);
    drive(OP_ST, 32'h0000_4020, 4'd1);
    @(negedge clk);
    drive(OP_IDLE, 32'h0, 4'd0);
    chk_all("R10", 0, 1, 1, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule